// File: doc/BRIEF.md
# Ranked Multi-Level Membership Filter

This block is a set-membership filter that keeps its occupancy in a stack of bit vectors instead of an array of counters. The first level holds one bit per hashed position and is the only level read when a membership question is asked, so a lookup costs one narrow read. Each further level records one more repeat of a position. A position that has been hit twice owns one entry in level two. The entry is the rank of that position in level one, meaning the number of set level-one bits below it. The same rule carries on from level two to level three, and so on.

A client computes K hash indices for an element elsewhere and presents them with one of three commands. A query answers in the next cycle with a member bit. An insert or a delete walks the K indices one per cycle, and the block holds its ready output low while it does. A repeat that would need a level beyond the deepest one is dropped and reported on a one-cycle overflow pulse. When a bit appears in or disappears from a level, the entries of the level below move up or down by one, so that rank addressing stays correct.

Top module: `ranked_bloom`

## Requirements
- R1: After reset every position is empty, cmd_ready is 1, resp_valid and ovf are 0, and every query answers 0.
- R2: A query accepted at a clock edge (cmd_valid and cmd_ready high, cmd_op = 2'b00) raises resp_valid for exactly one cycle, starting right after that edge.
- R3: resp_member is 1 only when every one of the K level-one positions named in the query is occupied. One empty position makes it 0.
- R4: An insert (cmd_op = 2'b01) adds one occurrence for each of its indices. The first occurrence of a position sets its level-one bit, and the n-th occurrence sets the position's entry in level n.
- R5: An insert index whose position already holds LEVELS occurrences changes no state and produces one ovf pulse, one cycle wide, for that index.
- R6: A delete (cmd_op = 2'b10) removes the deepest occurrence of each index first. A position stays a member until all of its occurrences have been removed.
- R7: A delete index whose position is empty has no effect and produces no ovf pulse.
- R8: After an insert or delete is accepted, cmd_ready is 0 for exactly K cycles. Commands offered during that time are not accepted and produce no response.
- R9: Occurrences recorded at one position are unaffected by inserts and deletes at other positions, including positions of lower rank that shift the entries of deeper levels.
- R10: The K indices are handled in order, one per cycle, and an index that repeats inside one command counts once for each time it appears.
- R11: cmd_op = 2'b11 is accepted and ignored. It changes no state, gives no response and does not lower cmd_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_op | input | 2 | 00 query, 01 insert, 10 delete, 11 no operation |
| cmd_idx | input | K*IDX_W | K hash indices. Index k is held in bits [k*IDX_W +: IDX_W] |
| cmd_ready | output | 1 | High when a command can be accepted |
| resp_valid | output | 1 | One-cycle pulse that carries a query answer |
| resp_member | output | 1 | Query answer, valid while resp_valid is high |
| ovf | output | 1 | One-cycle pulse for each dropped insert index |

## Verification
Directed sequences pile the K indices onto one position until it overflows, then drain it one step at a time. The queries between the steps show whether deletions remove the deepest occurrence first and whether dropped inserts left any trace. A second sequence fills a high position to full depth and then inserts at a lower position, so that the deeper levels must shift. Removing the high position afterwards shows whether rank addressing survived the shift. Random commands drawn from a small index range cause frequent collisions, repeats within one command, and deletes of empty positions. Each answer and each overflow count is compared with a plain occurrence-count model of the filter.

// File: rtl/rbf_pkg.sv
package rbf_pkg;
  typedef enum logic [1:0] {
    OP_QUERY  = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_NONE   = 2'b11
  } rbf_op_e;
endpackage

// File: rtl/rbf_level.sv
// One level of the ranked store. A bit can be set or cleared at an entry, and a slot can be
// opened (entries at and above the slot move up, a zero goes in) or closed (they move down).
module rbf_level #(
  parameter int NBITS = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [IDX_W-1:0] slot_idx,
  output logic [NBITS-1:0] vec
);
  function automatic logic [NBITS-1:0] below_mask(input logic [IDX_W-1:0] s);
    logic [NBITS-1:0] m;
    for (int i = 0; i < NBITS; i++) m[i] = (IDX_W'(i) < s);
    return m;
  endfunction

  function automatic logic [NBITS-1:0] slot_open(input logic [NBITS-1:0] v, input logic [IDX_W-1:0] s);
    logic [NBITS-1:0] m;
    m = below_mask(s);
    return (v & m) | ((v << 1) & ~m & ~(NBITS'(1) << s));
  endfunction

  function automatic logic [NBITS-1:0] slot_close(input logic [NBITS-1:0] v, input logic [IDX_W-1:0] s);
    logic [NBITS-1:0] m;
    m = below_mask(s);
    return (v & m) | ((v >> 1) & ~m);
  endfunction

  logic [NBITS-1:0] nxt;

  always_comb begin
    nxt = vec;
    if (set_en) nxt[bit_idx] = 1'b1;
    if (clr_en) nxt[bit_idx] = 1'b0;
    if (open_en) nxt = slot_open(nxt, slot_idx);
    if (close_en) nxt = slot_close(nxt, slot_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec <= '0;
    else        vec <= nxt;
  end
endmodule

// File: rtl/rbf_walk.sv
// Follows one position down through the levels by rank. It gives the entry addressed in every
// level and the number of levels in which that position is occupied.
module rbf_walk #(
  parameter int NBITS   = 16,
  parameter int LEVELS  = 3,
  parameter int IDX_W   = 4,
  parameter int DEPTH_W = 2
) (
  input  logic [LEVELS-1:0][NBITS-1:0] lv,
  input  logic [IDX_W-1:0]             pos,
  output logic [LEVELS-1:0][IDX_W-1:0] ent,
  output logic [DEPTH_W-1:0]           depth
);
  function automatic logic [IDX_W-1:0] ones_below(input logic [NBITS-1:0] v, input logic [IDX_W-1:0] e);
    logic [IDX_W-1:0] c;
    c = '0;
    for (int i = 0; i < NBITS; i++)
      if (IDX_W'(i) < e && v[i]) c = c + 1'b1;
    return c;
  endfunction

  logic [LEVELS-1:0] hit;

  assign ent[0] = pos;
  assign hit[0] = lv[0][pos];

  for (genvar j = 1; j < LEVELS; j++) begin : g_chain
    assign ent[j] = ones_below(lv[j-1], ent[j-1]);
    assign hit[j] = hit[j-1] & lv[j][ent[j]];
  end

  assign depth = DEPTH_W'($countones(hit));
endmodule

// File: rtl/rbf_seq.sv
// Latches the K indices of an insert or delete and presents one of them per cycle.
module rbf_seq #(
  parameter int K     = 3,
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              start_op,
  input  logic [K-1:0][IDX_W-1:0] start_idx,
  output logic                    busy,
  output logic [1:0]              cur_op,
  output logic [IDX_W-1:0]        cur_idx
);
  localparam int STEP_W = (K > 1) ? $clog2(K) : 1;

  logic [K-1:0][IDX_W-1:0] idx_q;
  logic [STEP_W-1:0]       step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      cur_op <= 2'b00;
      step   <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      idx_q  <= start_idx;
      cur_op <= start_op;
      step   <= '0;
      busy   <= 1'b1;
    end else if (busy) begin
      if (step == STEP_W'(K - 1)) busy <= 1'b0;
      else                        step <= step + 1'b1;
    end
  end

  assign cur_idx = idx_q[step];
endmodule

// File: rtl/ranked_bloom.sv
module ranked_bloom #(
  parameter int NBITS  = 16,
  parameter int K      = 3,
  parameter int LEVELS = 3,
  parameter int IDX_W  = $clog2(NBITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [K*IDX_W-1:0] cmd_idx,
  output logic               cmd_ready,
  output logic               resp_valid,
  output logic               resp_member,
  output logic               ovf
);
  import rbf_pkg::*;
  localparam int DEPTH_W = $clog2(LEVELS + 1);

  logic [LEVELS-1:0][NBITS-1:0] lv;
  logic [LEVELS-1:0][IDX_W-1:0] ent;
  logic [DEPTH_W-1:0]           depth;
  logic [K-1:0][IDX_W-1:0]      qidx;
  logic                         busy, accept, start, member_c;
  logic [1:0]                   cur_op;
  logic [IDX_W-1:0]             cur_idx;

  // Step events, brought out by name for the checker
  logic ins_step, del_step, ins_ok, del_ok, ins_drop;
  logic [LEVELS-1:0] set_en, clr_en, open_en, close_en;

  assign qidx      = cmd_idx;
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && (cmd_op == OP_INSERT || cmd_op == OP_DELETE);

  rbf_seq #(.K(K), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(cmd_op), .start_idx(qidx),
    .busy(busy), .cur_op(cur_op), .cur_idx(cur_idx)
  );

  rbf_walk #(.NBITS(NBITS), .LEVELS(LEVELS), .IDX_W(IDX_W), .DEPTH_W(DEPTH_W)) u_walk (
    .lv(lv), .pos(cur_idx), .ent(ent), .depth(depth)
  );

  assign ins_step = busy && (cur_op == OP_INSERT);
  assign del_step = busy && (cur_op == OP_DELETE);
  assign ins_ok   = ins_step && (depth != DEPTH_W'(LEVELS));
  assign ins_drop = ins_step && (depth == DEPTH_W'(LEVELS));
  assign del_ok   = del_step && (depth != '0);

  for (genvar j = 0; j < LEVELS; j++) begin : g_lvl
    assign set_en[j] = ins_ok && (depth == DEPTH_W'(j));
    assign clr_en[j] = del_ok && (depth == DEPTH_W'(j + 1));
    if (j == 0) begin : g_top
      assign open_en[j]  = 1'b0;
      assign close_en[j] = 1'b0;
    end else begin : g_deep
      assign open_en[j]  = ins_ok && (depth == DEPTH_W'(j - 1));
      assign close_en[j] = del_ok && (depth == DEPTH_W'(j));
    end
    rbf_level #(.NBITS(NBITS), .IDX_W(IDX_W)) u_level (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en[j]), .clr_en(clr_en[j]), .bit_idx(ent[j]),
      .open_en(open_en[j]), .close_en(close_en[j]), .slot_idx(ent[j]),
      .vec(lv[j])
    );
  end

  always_comb begin
    member_c = 1'b1;
    for (int k = 0; k < K; k++) member_c = member_c & lv[0][qidx[k]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_member <= 1'b0;
      ovf         <= 1'b0;
    end else begin
      resp_valid  <= accept && (cmd_op == OP_QUERY);
      if (accept && cmd_op == OP_QUERY) resp_member <= member_c;
      ovf         <= ins_drop;
    end
  end
endmodule

// File: rtl/rbf_chk.sv
module rbf_chk #(
  parameter int NBITS   = 16,
  parameter int LEVELS  = 3,
  parameter int DEPTH_W = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cmd_valid,
  input logic                         cmd_ready,
  input logic [1:0]                   cmd_op,
  input logic                         resp_valid,
  input logic                         ovf,
  input logic                         busy,
  input logic                         ins_ok,
  input logic                         ins_drop,
  input logic                         del_ok,
  input logic                         del_step,
  input logic [LEVELS-1:0][NBITS-1:0] lv
);
  int total;
  always_comb begin
    total = 0;
    for (int j = 0; j < LEVELS; j++) total += $countones(lv[j]);
  end

  assert_resp_after_query_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(cmd_valid && cmd_ready && cmd_op == 2'b00));

  assert_l1_stable_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(lv[0]));

  assert_insert_adds_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ok |=> total == $past(total) + 1);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ins_drop |=> ovf && $stable(lv));

  assert_delete_removes_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    del_ok |=> total == $past(total) - 1);

  assert_empty_delete_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (del_step && !del_ok) |=> $stable(lv) && !ovf);

  assert_busy_after_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op == 2'b01 || cmd_op == 2'b10)) |=> !cmd_ready);

  for (genvar j = 1; j < LEVELS; j++) begin : g_rank
    assert_rank_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lv[j]) <= $countones(lv[j-1]));
  end
endmodule

bind ranked_bloom rbf_chk #(.NBITS(NBITS), .LEVELS(LEVELS), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .resp_valid(resp_valid), .ovf(ovf), .busy(busy), .ins_ok(ins_ok), .ins_drop(ins_drop),
  .del_ok(del_ok), .del_step(del_step), .lv(lv)
);

// File: tb/ranked_bloom_test.sv
module ranked_bloom_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS  = 16;
  localparam int K      = 3;
  localparam int LEVELS = 3;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [K*IDX_W-1:0] cmd_idx = '0;
  logic cmd_ready, resp_valid, resp_member, ovf;

  int checks = 0;
  int failures = 0;
  int cnt [NBITS];

  always #(CLK_PERIOD/2) clk = ~clk;

  ranked_bloom #(.NBITS(NBITS), .K(K), .LEVELS(LEVELS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_ready(cmd_ready), .resp_valid(resp_valid), .resp_member(resp_member), .ovf(ovf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit model_member(input int a, input int b, input int c);
    return (cnt[a] > 0) && (cnt[b] > 0) && (cnt[c] > 0);
  endfunction

  task automatic query(input int a, input int b, input int c, input string tag);
    bit exp;
    exp = model_member(a, b, c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00;
    cmd_idx = {IDX_W'(c), IDX_W'(b), IDX_W'(a)};
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check(resp_valid === 1'b1, "R2", int'(resp_valid), 1);
    check(resp_member === exp, tag, int'(resp_member), int'(exp));
    @(posedge clk); @(negedge clk);
    check(resp_valid === 1'b0, "R2", int'(resp_valid), 0);
  endtask

  // op 1 = insert, 2 = delete; hold_probe offers a query while busy (R8)
  task automatic update(input logic [1:0] op, input int a, input int b, input int c,
                        input bit hold_probe);
    int ix [3];
    int exp_ovf;
    int got_ovf;
    bit saw_resp;
    ix = '{a, b, c};
    exp_ovf = 0; got_ovf = 0; saw_resp = 1'b0;
    for (int k = 0; k < K; k++) begin
      if (op == 2'b01) begin
        if (cnt[ix[k]] < LEVELS) cnt[ix[k]]++;
        else exp_ovf++;
      end else if (cnt[ix[k]] > 0) begin
        cnt[ix[k]]--;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    cmd_idx = {IDX_W'(c), IDX_W'(b), IDX_W'(a)};
    @(posedge clk); @(negedge clk);
    if (hold_probe) cmd_op = 2'b00;
    else cmd_valid = 1'b0;
    check(cmd_ready === 1'b0, "R8", int'(cmd_ready), 0);
    for (int s = 0; s < K; s++) begin
      if (hold_probe && s == K - 1) cmd_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      if (ovf) got_ovf++;
      if (resp_valid) saw_resp = 1'b1;
    end
    check(cmd_ready === 1'b1, "R8", int'(cmd_ready), 1);
    if (hold_probe) check(saw_resp == 1'b0, "R8", int'(saw_resp), 0);
    if (op == 2'b01) check(got_ovf == exp_ovf, "R5", got_ovf, exp_ovf);
    else             check(got_ovf == 0, "R7", got_ovf, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBITS; i++) cnt[i] = 0;
    void'($urandom(32'd5171));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty after reset
    check(cmd_ready === 1'b1, "R1", int'(cmd_ready), 1);
    check(resp_valid === 1'b0, "R1", int'(resp_valid), 0);
    check(ovf === 1'b0, "R1", int'(ovf), 0);
    query(0, 5, 15, "R1");
    query(7, 7, 7, "R1");

    // R4 / R10: one index repeated fills every level
    update(2'b01, 5, 5, 5, 1'b0);
    query(5, 5, 5, "R4");
    query(5, 6, 5, "R3");
    // R5: two repeats of position 5 are dropped, 9 is inserted
    update(2'b01, 5, 9, 5, 1'b0);
    query(9, 5, 9, "R10");
    // R6 / R7: remove deepest first; 0 is empty
    update(2'b10, 5, 5, 0, 1'b0);
    query(5, 5, 5, "R6");
    query(0, 0, 0, "R7");
    update(2'b10, 5, 0, 0, 1'b0);
    query(5, 5, 5, "R6");

    // R9: a lower position shifts deeper entries of a fuller one
    update(2'b01, 10, 10, 10, 1'b0);
    update(2'b01, 3, 3, 12, 1'b1);
    update(2'b01, 1, 12, 1, 1'b0);
    update(2'b10, 10, 10, 10, 1'b0);
    query(10, 10, 10, "R9");
    query(3, 3, 12, "R9");
    update(2'b10, 3, 12, 12, 1'b0);
    query(3, 1, 3, "R9");
    query(12, 12, 12, "R9");
    update(2'b10, 1, 1, 3, 1'b0);
    query(1, 1, 1, "R9");
    query(3, 3, 3, "R9");

    // R11: reserved op is taken and ignored
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_idx = {4'd9, 4'd9, 4'd9};
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready === 1'b1, "R11", int'(cmd_ready), 1);
    check(resp_valid === 1'b0, "R11", int'(resp_valid), 0);
    query(9, 9, 9, "R11");

    // Random mix on a narrow index range for frequent collisions
    for (int n = 0; n < 400; n++) begin
      int a, b, c, sel;
      sel = $urandom_range(0, 9);
      a = $urandom_range(0, 7);
      b = ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 7);
      c = $urandom_range(0, 9);
      if (sel < 4)      update(2'b01, a, b, c, sel == 0);
      else if (sel < 7) update(2'b10, a, b, c, 1'b0);
      else              query(a, b, c, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule